// File: doc/BRIEF.md
# Looping Modulo-2^W Operand Accumulator

This block adds a stream of unsigned operands together, modulo 2 to the power of the data width, using a single adder and one register that holds the running sum. A caller pulses a start strobe together with the number of terms it will send. It then presents the operands one at a time from a memory-like source, each qualified by a valid flag. The same hardware serves any term count from zero up to the limit of the count field. Only the control changes: the count is latched and a down-counter tracks how many terms are still outstanding.

The running sum is cleared when start is seen. Exactly one operand is added in each cycle that carries a valid operand during a job. After the last expected term has been taken, a one-cycle completion pulse appears and the final sum stays on the result port until the next start. With the default 8-bit width, eight terms take eight accepting cycles and a hundred terms take a hundred.

Top module: `modsum_loop`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `busy_o` and `done_o` are 0 and `sum_o` is 0.
- R2: In the cycle after `start_i` is sampled high, `sum_o` is 0. `busy_o` is 1 in that cycle if `count_i` was nonzero.
- R3: While `busy_o` is 1 and `start_i` is 0, each cycle with `op_valid_i` high replaces `sum_o` by (`sum_o` + `op_data_i`) mod 2^DATA_W in the next cycle.
- R4: During a job, a cycle with `op_valid_i` low leaves `sum_o` unchanged and does not count toward the term total.
- R5: After exactly `count_i` accepted operands, `done_o` is 1 for one cycle only. In that same cycle `busy_o` is 0 and `sum_o` holds the full modular sum.
- R6: While idle, `sum_o` stays constant until the next start, and operands presented while idle are ignored.
- R7: A start with `count_i` equal to 0 gives `done_o` = 1, `busy_o` = 0 and `sum_o` = 0 in the following cycle.
- R8: A start that arrives during a job abandons that job and begins again from zero with the new count. The abandoned job produces no `done_o`.
- R9: An operand presented in the same cycle as `start_i` is not added.
- R10: Setting `ADD_KIND` to either adder variant (ripple chain or native operator) gives the same results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a new job; clears the sum and latches the count |
| count_i | input | CNT_W | Number of operands in the job (0 allowed) |
| op_valid_i | input | 1 | Operand on `op_data_i` is present this cycle |
| op_data_i | input | DATA_W | Unsigned operand |
| busy_o | output | 1 | A job is in progress and operands are being accepted |
| done_o | output | 1 | One-cycle pulse: the result is final |
| sum_o | output | DATA_W | Running sum during a job, final sum afterwards |

## Verification
The properties assume that `op_data_i` and `op_valid_i` are known (not X) in every cycle where `busy_o` is 1, because the next-cycle sum is stated in terms of them. The bench drives those inputs at the falling edge, holds `op_valid_i` low with a defined data value between jobs, and presents a deliberate junk operand alongside each start so that R9 is exercised. Gaps in the operand stream are inserted at several random densities so that the hold behaviour is covered inside jobs as well as at their edges.

// File: rtl/modsum_pkg.sv
package modsum_pkg;
   typedef enum logic [0:0] {
      ADD_NATIVE = 1'b0,
      ADD_RIPPLE = 1'b1
   } add_kind_e;
endpackage

// File: rtl/modsum_adder.sv
module modsum_adder
   import modsum_pkg::*;
#(
   parameter int        DATA_W   = 8,
   parameter add_kind_e ADD_KIND = ADD_NATIVE
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   output logic [DATA_W-1:0] s_o
);
   generate
      if (ADD_KIND == ADD_RIPPLE) begin : g_ripple
         logic [DATA_W-1:0] cy;
         assign cy[0] = 1'b0;
         for (genvar i = 0; i < DATA_W; i++) begin : g_bit
            assign s_o[i] = a_i[i] ^ b_i[i] ^ cy[i];
            if (i < DATA_W - 1) begin : g_cy
               assign cy[i+1] = (a_i[i] & b_i[i]) | (cy[i] & (a_i[i] ^ b_i[i]));
            end
         end
      end else begin : g_native
         assign s_o = a_i + b_i;
      end
   endgenerate
endmodule

// File: rtl/modsum_ctr.sv
module modsum_ctr #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   input  logic             dec_i,
   output logic             last_o
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_q <= '0;
      end else if (load_i) begin
         left_q <= load_val_i;
      end else if (dec_i && left_q != '0) begin
         left_q <= left_q - ONE;
      end
   end

   assign last_o = (left_q == ONE);
endmodule

// File: rtl/modsum_acc.sv
module modsum_acc #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              en_i,
   input  logic [DATA_W-1:0] next_i,
   output logic [DATA_W-1:0] acc_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_o <= '0;
      end else if (clr_i) begin
         acc_o <= '0;
      end else if (en_i) begin
         acc_o <= next_i;
      end
   end
endmodule

// File: rtl/modsum_loop.sv
module modsum_loop
   import modsum_pkg::*;
#(
   parameter int        DATA_W   = 8,
   parameter int        CNT_W    = 8,
   parameter add_kind_e ADD_KIND = ADD_NATIVE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [CNT_W-1:0]  count_i,
   input  logic              op_valid_i,
   input  logic [DATA_W-1:0] op_data_i,
   output logic              busy_o,
   output logic              done_o,
   output logic [DATA_W-1:0] sum_o
);
   generate
      if (DATA_W < 1) begin : g_bad_data_w
         $error("modsum_loop: DATA_W must be at least 1");
      end
      if (CNT_W < 1) begin : g_bad_cnt_w
         $error("modsum_loop: CNT_W must be at least 1");
      end
   endgenerate

   logic              busy_q;
   logic              done_q;
   logic              take;
   logic              is_last;
   logic              cnt_zero;
   logic [DATA_W-1:0] acc;
   logic [DATA_W-1:0] acc_next;

   assign take     = busy_q & op_valid_i & ~start_i;
   assign cnt_zero = (count_i == '0);

   modsum_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (start_i),
      .load_val_i (count_i),
      .dec_i      (take),
      .last_o     (is_last)
   );

   modsum_adder #(.DATA_W(DATA_W), .ADD_KIND(ADD_KIND)) u_add (
      .a_i (acc),
      .b_i (op_data_i),
      .s_o (acc_next)
   );

   modsum_acc #(.DATA_W(DATA_W)) u_acc (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (start_i),
      .en_i   (take),
      .next_i (acc_next),
      .acc_o  (acc)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
      end else if (start_i) begin
         busy_q <= ~cnt_zero;
         done_q <= cnt_zero;
      end else begin
         done_q <= take & is_last;
         if (take && is_last) begin
            busy_q <= 1'b0;
         end
      end
   end

   assign busy_o = busy_q;
   assign done_o = done_q;
   assign sum_o  = acc;
endmodule

// File: rtl/modsum_loop_chk.sv
module modsum_loop_chk #(
   parameter int DATA_W = 8,
   parameter int CNT_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic [CNT_W-1:0]  count_i,
   input logic              op_valid_i,
   input logic [DATA_W-1:0] op_data_i,
   input logic              busy_o,
   input logic              done_o,
   input logic [DATA_W-1:0] sum_o
);
   p_start_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (sum_o == '0));

   p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && count_i != '0) |=> busy_o);

   p_add_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && op_valid_i && !start_i)
         |=> (sum_o == DATA_W'($past(sum_o) + $past(op_data_i))));

   p_gap_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !op_valid_i && !start_i) |=> $stable(sum_o));

   p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

   p_done_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) |-> ($past(busy_o) || $past(start_i)));

   p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !start_i) |=> ($stable(sum_o) && !busy_o));

   p_zero_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && count_i == '0) |=> (done_o && !busy_o));
endmodule

bind modsum_loop modsum_loop_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start_i    (start_i),
   .count_i    (count_i),
   .op_valid_i (op_valid_i),
   .op_data_i  (op_data_i),
   .busy_o     (busy_o),
   .done_o     (done_o),
   .sum_o      (sum_o)
);

// File: tb/sim_modsum_loop.sv
module sim_modsum_loop;
   import modsum_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam int DW = 8;
   localparam int CW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic [CW-1:0] count_i = '0;
   logic          op_valid_i = 1'b0;
   logic [DW-1:0] op_data_i = '0;
   logic          busy_o, done_o;
   logic [DW-1:0] sum_o;
   logic          busy_r, done_r;
   logic [DW-1:0] sum_r;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 1'b0;
   bit prev_done = 1'b0;
   logic [DW-1:0] expq[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   modsum_loop #(.DATA_W(DW), .CNT_W(CW), .ADD_KIND(ADD_NATIVE)) u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .count_i(count_i),
      .op_valid_i(op_valid_i), .op_data_i(op_data_i),
      .busy_o(busy_o), .done_o(done_o), .sum_o(sum_o)
   );

   // R10: second instance with the ripple adder, fed the same stimulus
   modsum_loop #(.DATA_W(DW), .CNT_W(CW), .ADD_KIND(ADD_RIPPLE)) u_rip (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .count_i(count_i),
      .op_valid_i(op_valid_i), .op_data_i(op_data_i),
      .busy_o(busy_r), .done_o(done_r), .sum_o(sum_r)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic wrap_up();
      if (!finished) begin
         finished = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   // monitor: pops expected results when completion is signalled
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         check(sum_o == sum_r && busy_o == busy_r && done_o == done_r, "R10",
               int'(sum_r), int'(sum_o));
         if (done_o) begin
            check(!prev_done, "R5 single pulse", 1, 0);
            if (expq.size() == 0) begin
               check(1'b0, "R8 unexpected done", 1, 0);
            end else begin
               logic [DW-1:0] e;
               e = expq.pop_front();
               check(sum_o == e, "R5 final sum", int'(sum_o), int'(e));
            end
         end
         prev_done = done_o;
      end
   end

   task automatic do_start(input int n);
      @(negedge clk);
      start_i    = 1'b1;
      count_i    = CW'(n);
      op_valid_i = 1'b1;          // R9: this operand must be ignored
      op_data_i  = 8'hA5;
      @(negedge clk);
      start_i    = 1'b0;
      op_valid_i = 1'b0;
      check(sum_o == '0, "R2 cleared", int'(sum_o), 0);
      check(busy_o == (n != 0), "R2 busy", int'(busy_o), int'(n != 0));
   endtask

   // feeds n operands with a gap probability; returns modular sum
   task automatic feed(input int n, input int gap_pct, output logic [DW-1:0] run);
      int fed = 0;
      bit last_v = 1'b0;
      run = '0;
      while (fed < n) begin
         if (gap_pct > 0 && ($urandom % 100) < gap_pct) begin
            op_valid_i = 1'b0;
            op_data_i  = DW'($urandom);
            last_v = 1'b0;
         end else begin
            op_valid_i = 1'b1;
            op_data_i  = DW'($urandom);
            run = run + op_data_i;
            fed++;
            last_v = 1'b1;
         end
         @(negedge clk);
         if (fed < n || !last_v)
            check(sum_o == run, last_v ? "R3" : "R4", int'(sum_o), int'(run));
      end
      op_valid_i = 1'b0;
   endtask

   task automatic run_job(input int n, input int gap_pct);
      logic [DW-1:0] exp_sum;
      do_start(n);
      if (n == 0) begin
         expq.push_back('0);
         check(done_o && !busy_o && sum_o == '0, "R7", int'(sum_o), 0);
         @(negedge clk);
      end else begin
         feed(n, gap_pct, exp_sum);
         expq.push_back(exp_sum);
         check(done_o == 1'b1, "R5 done", int'(done_o), 1);
         check(busy_o == 1'b0, "R5 busy low", int'(busy_o), 0);
         @(negedge clk);
         check(done_o == 1'b0, "R5 pulse end", int'(done_o), 0);
         // R6: idle operands ignored
         for (int k = 0; k < 3; k++) begin
            op_valid_i = 1'b1;
            op_data_i  = DW'($urandom);
            @(negedge clk);
            check(sum_o == exp_sum && !done_o && !busy_o, "R6", int'(sum_o), int'(exp_sum));
         end
         op_valid_i = 1'b0;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      check(1'b0, "watchdog", 0, 1);
      wrap_up();
   end

   initial begin
      logic [DW-1:0] junk;
      repeat (3) @(negedge clk);
      check(!busy_o && !done_o && sum_o == '0, "R1 in reset", int'(sum_o), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy_o && !done_o && sum_o == '0, "R1 after reset", int'(sum_o), 0);

      run_job(1, 0);
      run_job(8, 0);
      run_job(8, 40);
      run_job(100, 25);
      run_job(255, 10);
      run_job(0, 0);
      run_job(3, 60);

      // R8: abandon a job midway and restart
      do_start(10);
      feed(4, 0, junk);
      run_job(5, 20);
      check(expq.size() == 0, "R8 queue drained", expq.size(), 0);

      repeat (4) @(negedge clk);
      wrap_up();
   end
endmodule